// File: doc/BRIEF.md
# DMA Request and Interrupt Sequencer

A device-side sequencer for multi-sector data-transfer commands. The host starts a command with a one-cycle pulse that carries a sector count and a mode flag. The mode flag selects DMA or programmed I/O. For each sector, the block waits a fixed fetch delay that stands in for the media. It then opens a transfer window, counts the host's word strobes, and closes the window when the sector's words have all moved. It finishes the command after the last sector.

In DMA mode the block drives a level request line, active low by default. It can release that line a programmable number of words before each sector ends, so that a host which reacts late does not move words past the sector boundary. The words still owed are accepted after the line drops. In DMA mode one interrupt marks the end of the whole command. In programmed I/O the request line stays idle, and an interrupt announces every sector that is ready for the host. A status read clears a pending interrupt.

A soft-reset bit aborts a command. Busy stays high through a fixed drain period and then clears. A media failure ends the command early, with the interrupt raised.

Top module: `xfer_req_seq`

## Requirements
- R1: After reset, `dma_req_o` is high (inactive), `irq_o` is low and `busy_o` is low.
- R2: A start pulse while idle with `soft_rst_i` low makes `busy_o` high from the next cycle. A start pulse while busy is ignored and does not change the running command's word total.
- R3: Each sector holds 256 words. A sector count of 0 means 256 sectors, so such a command moves 65536 words.
- R4: Each sector first spends FETCH_CYC cycles fetching. Only after that are host word strobes accepted. Strobes during the fetch are ignored and do not count toward the sector.
- R5: In DMA mode, the request is active only while the words left in the current sector exceed `early_neg_i` (0 to 7). The words left after the request drops are still accepted by strobe until the sector is complete.
- R6: In DMA mode, `irq_o` rises only when the final word of the command is accepted, in the same cycle that `busy_o` falls.
- R7: In programmed I/O mode, `dma_req_o` is never active. `irq_o` rises each time a sector's fetch completes. Normal completion of the last sector raises no extra interrupt.
- R8: `irq_o` stays high until `status_rd_i` is sampled high. If a set event and a status read fall in the same cycle, the set wins.
- R9: While `soft_rst_i` is high, it clears `irq_o` and aborts the command. The request goes inactive on the next cycle, `busy_o` stays high for exactly ABORT_CYC cycles, and no interrupt is raised.
- R10: `media_fail_i` during a fetch or a transfer ends the command on the next edge. `busy_o` falls, `irq_o` rises, and the total is fewer words than requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_start_i | input | 1 | One-cycle command start pulse |
| cmd_sectors_i | input | 8 | Sector count for the command, 0 means 256 |
| cmd_dma_i | input | 1 | 1 selects DMA mode, 0 selects programmed I/O |
| host_word_i | input | 1 | Host moved one word this cycle |
| status_rd_i | input | 1 | Host status read, clears the interrupt |
| soft_rst_i | input | 1 | Soft-reset bit, aborts the command |
| early_neg_i | input | 3 | Words before sector end at which the request is released |
| media_fail_i | input | 1 | Media failure, ends the command early |
| dma_req_o | output | 1 | DMA request, level, active low by default |
| irq_o | output | 1 | Interrupt to the host |
| busy_o | output | 1 | Command in progress |

## Verification
A word counter that is off by one moves the request release point and changes the total words accepted per sector. The scoreboard shows this at the first interrupt, because it compares the words moved with the expected total at every interrupt rise. A wrong mode or state shows up at the ports within one cycle: an interrupt in the middle of a DMA command, a request during programmed I/O, or a request still active after a soft reset. The bounded checker catches each of these. A timer that is off by one in the abort drain shows in the count of busy cycles after the soft reset.

// File: rtl/xrs_pkg.sv
package xrs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_XFER  = 2'd2,
    ST_ABORT = 2'd3
  } xrs_state_e;
endpackage

// File: rtl/xrs_delay_tmr.sv
module xrs_delay_tmr #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - W'(1);
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/xrs_word_ctr.sv
module xrs_word_ctr #(
  parameter int WORDS = 256,
  parameter int NEG_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [NEG_W-1:0] neg_i,
  output logic             last_o,
  output logic             req_ok_o
);
  localparam int WCW = $clog2(WORDS);
  localparam logic [WCW:0]   WORDS_L  = (WCW+1)'(WORDS);
  localparam logic [WCW-1:0] LAST_IDX = WCW'(WORDS - 1);

  logic [WCW-1:0] cnt_q;
  logic [WCW:0]   left_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (inc_i)   cnt_q <= cnt_q + WCW'(1);
  end

  assign left_w   = WORDS_L - {1'b0, cnt_q};
  assign last_o   = (cnt_q == LAST_IDX);
  // request held only while more words remain than the early-release count
  assign req_ok_o = (left_w > (WCW+1)'(neg_i));
endmodule

// File: rtl/xrs_sector_ctr.sv
module xrs_sector_ctr #(
  parameter int SEC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [SEC_W-1:0] count_i,
  input  logic             dec_i,
  output logic             last_o
);
  localparam logic [SEC_W:0] FULL = (SEC_W+1)'(2**SEC_W);

  logic [SEC_W:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     left_q <= '0;
    else if (load_i) left_q <= (count_i == '0) ? FULL : {1'b0, count_i};
    else if (dec_i)  left_q <= left_q - (SEC_W+1)'(1);
  end

  assign last_o = (left_q == (SEC_W+1)'(1));
endmodule

// File: rtl/xrs_irq_ctl.sv
module xrs_irq_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic kill_i,
  output logic irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     irq_o <= 1'b0;
    else if (kill_i) irq_o <= 1'b0;
    else if (set_i)  irq_o <= 1'b1;
    else if (clr_i)  irq_o <= 1'b0;
  end
endmodule

// File: rtl/xfer_req_seq.sv
module xfer_req_seq
  import xrs_pkg::*;
#(
  parameter int WORDS_PER_SEC = 256,
  parameter int SEC_W         = 8,
  parameter int NEG_W         = 3,
  parameter int FETCH_CYC     = 4,
  parameter int ABORT_CYC     = 3,
  parameter bit REQ_ACT_HIGH  = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_start_i,
  input  logic [SEC_W-1:0] cmd_sectors_i,
  input  logic             cmd_dma_i,
  input  logic             host_word_i,
  input  logic             status_rd_i,
  input  logic             soft_rst_i,
  input  logic [NEG_W-1:0] early_neg_i,
  input  logic             media_fail_i,
  output logic             dma_req_o,
  output logic             irq_o,
  output logic             busy_o
);
  localparam int TMR_MAX = (FETCH_CYC > ABORT_CYC) ? FETCH_CYC : ABORT_CYC;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);

  xrs_state_e state_q, state_d;
  logic       dma_q;
  logic       accept, word_acc, fail_ev, sec_done, cmd_done, fetch_end;
  logic       tmr_load, tmr_zero, w_last, w_req_ok, s_last, req_act, irq_set;
  logic [TMR_W-1:0] tmr_val;

  assign accept    = (state_q == ST_IDLE) && cmd_start_i && !soft_rst_i;
  assign fail_ev   = media_fail_i && !soft_rst_i &&
                     ((state_q == ST_FETCH) || (state_q == ST_XFER));
  assign word_acc  = (state_q == ST_XFER) && host_word_i && !soft_rst_i && !media_fail_i;
  assign sec_done  = word_acc && w_last;
  assign cmd_done  = sec_done && s_last;
  assign fetch_end = (state_q == ST_FETCH) && tmr_zero && !soft_rst_i && !media_fail_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept) state_d = ST_FETCH;
      ST_FETCH: begin
        if (soft_rst_i)        state_d = ST_ABORT;
        else if (media_fail_i) state_d = ST_IDLE;
        else if (tmr_zero)     state_d = ST_XFER;
      end
      ST_XFER: begin
        if (soft_rst_i)        state_d = ST_ABORT;
        else if (media_fail_i) state_d = ST_IDLE;
        else if (cmd_done)     state_d = ST_IDLE;
        else if (sec_done)     state_d = ST_FETCH;
      end
      ST_ABORT: if (tmr_zero) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = TMR_W'(FETCH_CYC - 1);
    if (state_d == ST_FETCH && state_q != ST_FETCH) begin
      tmr_load = 1'b1;
    end else if (state_d == ST_ABORT && state_q != ST_ABORT) begin
      tmr_load = 1'b1;
      tmr_val  = TMR_W'(ABORT_CYC - 1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      dma_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) dma_q <= cmd_dma_i;
    end
  end

  xrs_delay_tmr #(.W(TMR_W)) i_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  xrs_word_ctr #(.WORDS(WORDS_PER_SEC), .NEG_W(NEG_W)) i_word_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (state_q != ST_XFER),
    .inc_i    (word_acc),
    .neg_i    (early_neg_i),
    .last_o   (w_last),
    .req_ok_o (w_req_ok)
  );

  xrs_sector_ctr #(.SEC_W(SEC_W)) i_sector_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .count_i (cmd_sectors_i),
    .dec_i   (sec_done),
    .last_o  (s_last)
  );

  // DMA: one interrupt per command; PIO: one per ready sector; failure always
  assign irq_set = fail_ev || (cmd_done && dma_q) || (fetch_end && !dma_q);

  xrs_irq_ctl i_irq_ctl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (irq_set),
    .clr_i  (status_rd_i),
    .kill_i (soft_rst_i),
    .irq_o  (irq_o)
  );

  assign req_act = (state_q == ST_XFER) && dma_q && w_req_ok;

  generate
    if (REQ_ACT_HIGH) begin : g_req_hi
      assign dma_req_o = req_act;
    end else begin : g_req_lo
      assign dma_req_o = ~req_act;
    end
  endgenerate

  assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/xrs_checker.sv
module xrs_checker #(
  parameter bit REQ_ACT_HIGH = 1'b0
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cmd_start_i,
  input logic status_rd_i,
  input logic soft_rst_i,
  input logic media_fail_i,
  input logic dma_q,
  input logic dma_req_o,
  input logic irq_o,
  input logic busy_o
);
  logic req_act;
  assign req_act = REQ_ACT_HIGH ? dma_req_o : ~dma_req_o;

  AST_BUSY_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && cmd_start_i && !soft_rst_i |=> busy_o); // R2
  AST_REQ_NEEDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_act |-> busy_o); // R4
  AST_DMA_IRQ_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) && dma_q |-> !busy_o); // R6
  AST_PIO_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !dma_q |-> !req_act); // R7
  AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !status_rd_i && !soft_rst_i |=> irq_o); // R8
  AST_SRST_DROPS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> !req_act); // R9
  AST_SRST_CLEARS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> !irq_o); // R9
  AST_FAIL_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    media_fail_i && req_act && !soft_rst_i |=> !busy_o && irq_o); // R10
endmodule

bind xfer_req_seq xrs_checker #(.REQ_ACT_HIGH(REQ_ACT_HIGH)) i_xrs_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_start_i  (cmd_start_i),
  .status_rd_i  (status_rd_i),
  .soft_rst_i   (soft_rst_i),
  .media_fail_i (media_fail_i),
  .dma_q        (dma_q),
  .dma_req_o    (dma_req_o),
  .irq_o        (irq_o),
  .busy_o       (busy_o)
);

// File: tb/test_xfer_req_seq.sv
module test_xfer_req_seq;
  localparam int CLK_PERIOD = 10;
  localparam int ABORT_N    = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] secs = '0;
  logic       dma = 1'b0;
  logic       word = 1'b0;
  logic       rd = 1'b0;
  logic       srst = 1'b0;
  logic [2:0] neg = '0;
  logic       fail = 1'b0;
  logic       req_n, irq, busy;

  int n_tests = 0;
  int n_fail  = 0;
  int tot     = 0;
  int act_cnt = 0;
  int req_seen = 0;
  int exp_q[$];
  logic irq_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xfer_req_seq #(.ABORT_CYC(ABORT_N)) i_xfer_req_seq (
    .clk_i(clk), .rst_ni(rst_n), .cmd_start_i(start), .cmd_sectors_i(secs),
    .cmd_dma_i(dma), .host_word_i(word), .status_rd_i(rd), .soft_rst_i(srst),
    .early_neg_i(neg), .media_fail_i(fail), .dma_req_o(req_n), .irq_o(irq),
    .busy_o(busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  // scoreboard monitor: each interrupt rise must match the next expected word total
  always @(negedge clk) begin
    if (rst_n && irq && !irq_prev) begin
      if (exp_q.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R6 unexpected interrupt at word total: got %0d expected none", tot);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk(tot == e, "R8 interrupt word total", tot, e);
      end
    end
    irq_prev = irq;
  end

  task automatic dma_host(input int extra, input int limit);
    int rem;
    bit was;
    rem = 0; was = 0; act_cnt = 0;
    forever begin
      tick();
      word = 1'b0;
      if (!busy || tot >= limit) break;
      if (!req_n) begin
        word = 1'b1; tot++; act_cnt++; was = 1;
      end else begin
        if (was) begin rem = extra; was = 0; end
        if (rem > 0) begin word = 1'b1; tot++; rem--; end
      end
    end
  endtask

  task automatic pio_host(input int nsec);
    req_seen = 0;
    for (int s = 0; s < nsec; s++) begin
      forever begin tick(); if (irq) break; end
      rd = 1'b1;
      for (int w = 0; w < 256; w++) begin
        tick(); rd = 1'b0; word = 1'b1; tot++;
        if (!req_n) req_seen++;
      end
      tick(); word = 1'b0;
    end
    while (busy) tick();
  endtask

  task automatic launch(input int n, input bit d, input int ng);
    tot = 0;
    tick(); start = 1'b1; secs = 8'(n); dma = d; neg = 3'(ng);
    tick(); start = 1'b0;
  endtask

  task automatic clear_irq();
    rd = 1'b1; tick(); rd = 1'b0; tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL R4 watchdog expired: got 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int n;
    repeat (3) tick();
    chk(req_n == 1'b1, "R1 request idle", int'(req_n), 1);
    chk(irq == 1'b0, "R1 irq idle", int'(irq), 0);
    chk(busy == 1'b0, "R1 busy idle", int'(busy), 0);
    rst_n = 1'b1;
    tick();

    // DMA, 2 sectors, no early release; stray strobe in fetch and ignored restart
    exp_q.push_back(512);
    launch(2, 1'b1, 0);
    chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    word = 1'b1; start = 1'b1; secs = 8'd1;
    tick(); word = 1'b0; start = 1'b0;
    dma_host(0, 1 << 30);
    chk(tot == 512, "R4 words moved, fetch strobe ignored, restart ignored", tot, 512);
    chk(busy == 1'b0, "R6 busy cleared at end", int'(busy), 0);
    chk(irq == 1'b1, "R6 irq at command end", int'(irq), 1);
    rd = 1'b1; tick(); rd = 1'b0;
    chk(irq == 1'b0, "R8 status read clears irq", int'(irq), 0);

    // DMA, early release by 3 words, late host moves the remainder
    exp_q.push_back(256);
    launch(1, 1'b1, 3);
    dma_host(3, 1 << 30);
    chk(act_cnt == 253, "R5 words under active request", act_cnt, 253);
    chk(tot == 256, "R5 remainder accepted", tot, 256);
    clear_irq();

    // DMA, early release by 7 on two sectors
    exp_q.push_back(512);
    launch(2, 1'b1, 7);
    dma_host(7, 1 << 30);
    chk(act_cnt == 498, "R5 release at 7 per sector", act_cnt, 498);
    chk(tot == 512, "R5 total with release 7", tot, 512);
    clear_irq();

    // programmed I/O, 3 sectors: one irq per ready sector
    exp_q.push_back(0); exp_q.push_back(256); exp_q.push_back(512);
    launch(3, 1'b0, 0);
    pio_host(3);
    chk(tot == 768, "R7 PIO words moved", tot, 768);
    chk(req_seen == 0, "R7 no request in PIO", req_seen, 0);
    chk(irq == 1'b0, "R7 no completion irq in PIO", int'(irq), 0);
    chk(exp_q.size() == 0, "R7 all sector interrupts seen", exp_q.size(), 0);

    // soft reset during a DMA transfer
    launch(2, 1'b1, 0);
    dma_host(0, 100);
    srst = 1'b1; tick(); srst = 1'b0;
    chk(req_n == 1'b1, "R9 request dropped on abort", int'(req_n), 1);
    n = 0;
    while (busy && n < 50) begin n++; tick(); end
    chk(n == ABORT_N, "R9 busy held through abort drain", n, ABORT_N);
    chk(irq == 1'b0, "R9 no irq from abort", int'(irq), 0);

    // soft reset clears a pending PIO interrupt
    exp_q.push_back(0);
    launch(1, 1'b0, 0);
    forever begin tick(); if (irq) break; end
    srst = 1'b1; tick(); srst = 1'b0;
    chk(irq == 1'b0, "R9 pending irq cleared", int'(irq), 0);
    while (busy) tick();

    // media failure mid transfer
    exp_q.push_back(50);
    launch(2, 1'b1, 0);
    dma_host(0, 50);
    fail = 1'b1; tick(); fail = 1'b0;
    chk(busy == 1'b0, "R10 failure ends command", int'(busy), 0);
    chk(irq == 1'b1, "R10 failure raises irq", int'(irq), 1);
    clear_irq();

    // sector count 0 means 256 sectors
    exp_q.push_back(65536);
    launch(0, 1'b1, 0);
    dma_host(0, 1 << 30);
    chk(tot == 65536, "R3 zero count is 256 sectors", tot, 65536);
    chk(busy == 1'b0, "R3 busy clear after long command", int'(busy), 0);
    clear_irq();
    chk(exp_q.size() == 0, "R6 no missing interrupts", exp_q.size(), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule